// File: doc/BRIEF.md
# Write-Mode Selectable Synchronous RAM Port

This block is a single-port synchronous RAM. Every access happens on the rising clock edge, and the read data sits in an output register. An enable gates the whole port. A write strobe decides whether the addressed word is replaced. A synchronous output-clear input loads a constant into the output register, and this load never changes the stored words.

While a write is in progress, the output register follows one of three behaviours, picked at elaboration by the `WR_MODE` parameter:

- **Write-first:** the output shows the incoming word.
- **Read-first:** the output shows the word the location held before the write.
- **No-change:** the output keeps its previous value.

Data width, depth and the output-clear constant are all parameters. A mode value outside the three known codes stops elaboration with an error.

Top module: `wm_ram_port`

## Requirements
- R1: On a rising edge with `en_i`=1 and `we_i`=1, the word at `addr_i` takes the value of `din_i`. Any later read of that address returns the new word until it is written again.
- R2: On a rising edge with `en_i`=1, `we_i`=0 and `oclr_i`=0, `dout_o` takes the word stored at `addr_i`. It is valid from that edge, a latency of one edge.
- R3: With `WR_MODE`=0 (write-first), a write edge with `oclr_i`=0 loads `din_i` into `dout_o`.
- R4: With `WR_MODE`=1 (read-first), a write edge with `oclr_i`=0 loads into `dout_o` the word the addressed location held before that edge.
- R5: With `WR_MODE`=2 (no-change), a write edge with `oclr_i`=0 leaves `dout_o` unchanged, for as many write edges in a row as occur.
- R6: On an edge with `en_i`=0, nothing changes: no word is written, `dout_o` is not updated and `oclr_i` has no effect, whatever `we_i`, `oclr_i`, `addr_i` and `din_i` are.
- R7: On an edge with `en_i`=1 and `oclr_i`=1, `dout_o` takes `OCLR_VAL`. No stored word changes unless `we_i` is also 1.
- R8: When `oclr_i`=1 and `we_i`=1 on an enabled edge, the write of R1 still happens. `dout_o` shows `OCLR_VAL`, whatever the mode.
- R9: From start-up, `dout_o` equals `OCLR_VAL` until the first enabled edge. Every stored word starts at zero.
- R10: `WR_MODE` codes are 0 for write-first, 1 for read-first and 2 for no-change. Any other value is an elaboration error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all operations |
| en_i | input | 1 | Port enable; gates writes, output updates and output clear |
| we_i | input | 1 | Write strobe |
| oclr_i | input | 1 | Synchronous load of `OCLR_VAL` into the output register |
| addr_i | input | ADDR_W ($clog2(DEPTH)) | Word address |
| din_i | input | DATA_W | Write data |
| dout_o | output | DATA_W | Registered read data |

## Verification
Two functions can land on the same edge:

- **Write plus output clear.** A write and an output clear are both enabled on one edge. The bench forces this directly, and also provokes it at random: `oclr_i` is raised about one edge in ten while writes are common. The judgement is that `dout_o` shows the clear constant, and a later plain read of the same address returns the written word.
- **Write plus read-back.** A write and the mode-dependent read-back share the same edge. Each of the three modes gets its own instance, driven in lockstep. On every edge, each output is compared with a bench model that keeps the old word, the new word and the held output apart.

// File: rtl/wm_ram_pkg.sv
package wm_ram_pkg;

  localparam int WM_WRITE_FIRST = 0;
  localparam int WM_READ_FIRST  = 1;
  localparam int WM_NO_CHANGE   = 2;

  function automatic bit wm_mode_known(input int mode);
    return (mode == WM_WRITE_FIRST) || (mode == WM_READ_FIRST) ||
           (mode == WM_NO_CHANGE);
  endfunction

  function automatic int wm_addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/wm_ram_ctrl.sv
module wm_ram_ctrl (
  input  logic en_i,
  input  logic we_i,
  input  logic oclr_i,
  output logic wr_fire_o,
  output logic rd_fire_o,
  output logic clr_fire_o,
  output logic wrout_fire_o
);
  // the enable qualifies every event; clear outranks any data selection
  always_comb begin
    wr_fire_o    = en_i & we_i;
    clr_fire_o   = en_i & oclr_i;
    rd_fire_o    = en_i & ~we_i & ~oclr_i;
    wrout_fire_o = en_i & we_i & ~oclr_i;
  end
endmodule

// File: rtl/wm_ram_store.sv
module wm_ram_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_fire_i) mem[addr_i] <= din_i;
  end

  // combinational view of the addressed word: the pre-edge contents
  assign rd_word_o = mem[addr_i];
endmodule

// File: rtl/wm_ram_outreg.sv
module wm_ram_outreg
  import wm_ram_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              WR_MODE  = WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0] OCLR_VAL = '0
) (
  input  logic              clk,
  input  logic              clr_fire_i,
  input  logic              rd_fire_i,
  input  logic              wrout_fire_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_r = OCLR_VAL;
  logic [DATA_W-1:0] wr_sel;
  logic [DATA_W-1:0] q_nxt;

  generate
    if (WR_MODE == WM_WRITE_FIRST) begin : g_wf
      assign wr_sel = din_i;
    end else if (WR_MODE == WM_READ_FIRST) begin : g_rf
      assign wr_sel = rd_word_i;
    end else if (WR_MODE == WM_NO_CHANGE) begin : g_nc
      assign wr_sel = q_r;
    end else begin : g_bad
      $error("wm_ram_outreg: unknown WR_MODE %0d", WR_MODE);
      assign wr_sel = q_r;
    end
  endgenerate

  always_comb begin
    q_nxt = q_r;
    if (clr_fire_i)        q_nxt = OCLR_VAL;
    else if (rd_fire_i)    q_nxt = rd_word_i;
    else if (wrout_fire_i) q_nxt = wr_sel;
  end

  always_ff @(posedge clk) q_r <= q_nxt;

  assign q_o = q_r;
endmodule

// File: rtl/wm_ram_port.sv
module wm_ram_port
  import wm_ram_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                DEPTH    = 256,
  parameter int                WR_MODE  = WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0] OCLR_VAL = '0,
  localparam int               ADDR_W   = wm_addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              en_i,
  input  logic              we_i,
  input  logic              oclr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  generate
    if (!wm_mode_known(WR_MODE)) begin : g_mode_chk
      $error("wm_ram_port: WR_MODE %0d is not 0, 1 or 2", WR_MODE);
    end
  endgenerate

  // named internal events, visible to the bound checker
  logic              wr_fire;
  logic              rd_fire;
  logic              clr_fire;
  logic              wrout_fire;
  logic [DATA_W-1:0] rd_word;

  wm_ram_ctrl u_ctrl (
    .en_i        (en_i),
    .we_i        (we_i),
    .oclr_i      (oclr_i),
    .wr_fire_o   (wr_fire),
    .rd_fire_o   (rd_fire),
    .clr_fire_o  (clr_fire),
    .wrout_fire_o(wrout_fire)
  );

  wm_ram_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_store (
    .clk      (clk),
    .wr_fire_i(wr_fire),
    .addr_i   (addr_i),
    .din_i    (din_i),
    .rd_word_o(rd_word)
  );

  wm_ram_outreg #(
    .DATA_W(DATA_W), .WR_MODE(WR_MODE), .OCLR_VAL(OCLR_VAL)
  ) u_out (
    .clk         (clk),
    .clr_fire_i  (clr_fire),
    .rd_fire_i   (rd_fire),
    .wrout_fire_i(wrout_fire),
    .din_i       (din_i),
    .rd_word_i   (rd_word),
    .q_o         (dout_o)
  );
endmodule

// File: rtl/wm_ram_port_chk.sv
module wm_ram_port_chk #(
  parameter int                DATA_W   = 16,
  parameter int                WR_MODE  = 0,
  parameter logic [DATA_W-1:0] OCLR_VAL = '0
) (
  input logic              clk,
  input logic              en_i,
  input logic              we_i,
  input logic              oclr_i,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] dout_o,
  input logic [DATA_W-1:0] rd_word
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  always_comb begin
    if (!started) assert_powerup_R9: assert (dout_o == OCLR_VAL);
  end

  assert_read_R2: assert property (@(posedge clk) disable iff (!started)
    (en_i && !we_i && !oclr_i) |=> (dout_o == $past(rd_word)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!started)
    !en_i |=> $stable(dout_o));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!started)
    (en_i && oclr_i) |=> (dout_o == OCLR_VAL));

  // R8: a write never leaks through when the clear is active
  assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!started)
    (en_i && oclr_i && we_i) |=> (dout_o == OCLR_VAL));

  generate
    if (WR_MODE == 0) begin : g_wf
      assert_wfirst_R3: assert property (@(posedge clk) disable iff (!started)
        (en_i && we_i && !oclr_i) |=> (dout_o == $past(din_i)));
    end else if (WR_MODE == 1) begin : g_rf
      assert_rfirst_R4: assert property (@(posedge clk) disable iff (!started)
        (en_i && we_i && !oclr_i) |=> (dout_o == $past(rd_word)));
    end else begin : g_nc
      assert_nochg_R5: assert property (@(posedge clk) disable iff (!started)
        (en_i && we_i && !oclr_i) |=> $stable(dout_o));
    end
  endgenerate
endmodule

bind wm_ram_port wm_ram_port_chk #(
  .DATA_W(DATA_W), .WR_MODE(WR_MODE), .OCLR_VAL(OCLR_VAL)
) u_chk (
  .clk    (clk),
  .en_i   (en_i),
  .we_i   (we_i),
  .oclr_i (oclr_i),
  .din_i  (din_i),
  .dout_o (dout_o),
  .rd_word(rd_word)
);

// File: tb/wm_ram_port_tb.sv
module wm_ram_port_tb;
  localparam int DW = 16;
  localparam int DP = 16;
  localparam int AW = 4;
  localparam logic [DW-1:0] CLR = 16'hA5C3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic          en = 0, we = 0, oclr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] q_wf, q_rf, q_nc;

  wm_ram_port #(.DATA_W(DW), .DEPTH(DP), .WR_MODE(0), .OCLR_VAL(CLR)) u_dut (
    .clk(clk), .en_i(en), .we_i(we), .oclr_i(oclr), .addr_i(addr), .din_i(din), .dout_o(q_wf));
  wm_ram_port #(.DATA_W(DW), .DEPTH(DP), .WR_MODE(1), .OCLR_VAL(CLR)) u_dut_rf (
    .clk(clk), .en_i(en), .we_i(we), .oclr_i(oclr), .addr_i(addr), .din_i(din), .dout_o(q_rf));
  wm_ram_port #(.DATA_W(DW), .DEPTH(DP), .WR_MODE(2), .OCLR_VAL(CLR)) u_dut_nc (
    .clk(clk), .en_i(en), .we_i(we), .oclr_i(oclr), .addr_i(addr), .din_i(din), .dout_o(q_nc));

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] mdl_mem [DP];
  logic [DW-1:0] exp_q [3];

  function automatic logic [DW-1:0] next_out(input int mode, input logic e, input logic w,
      input logic c, input logic [DW-1:0] d, input logic [DW-1:0] old_word,
      input logic [DW-1:0] cur);
    if (!e) return cur;
    if (c) return CLR;
    if (!w) return old_word;
    case (mode)
      0: return d;
      1: return old_word;
      default: return cur;
    endcase
  endfunction

  function automatic string req_of(input int mode, input logic e, input logic w, input logic c);
    if (!e) return "R6";
    if (c && w) return "R8";
    if (c) return "R7";
    if (!w) return "R1/R2";
    case (mode)
      0: return "R3/R10";
      1: return "R4/R10";
      default: return "R5/R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic w, input logic c,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] old_word;
    en = e; we = w; oclr = c; addr = a; din = d;
    old_word = mdl_mem[a];
    for (int m = 0; m < 3; m++) exp_q[m] = next_out(m, e, w, c, d, old_word, exp_q[m]);
    if (e && w) mdl_mem[a] = d;
    @(posedge clk);
    @(negedge clk);
    check(req_of(0, e, w, c), q_wf, exp_q[0]);
    check(req_of(1, e, w, c), q_rf, exp_q[1]);
    check(req_of(2, e, w, c), q_nc, exp_q[2]);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DP; i++) mdl_mem[i] = '0;
    for (int m = 0; m < 3; m++) exp_q[m] = CLR;
    @(negedge clk);
    // R9: output clear value at start-up, held while disabled
    check("R9", q_wf, CLR); check("R9", q_rf, CLR); check("R9", q_nc, CLR);
    // R6: disabled edge with write and clear must do nothing
    cyc(0, 1, 1, 4'd3, 16'h1111);
    cyc(0, 1, 0, 4'd3, 16'h2222);
    // R9: unwritten word reads zero; R6: previous disabled writes left no trace
    cyc(1, 0, 0, 4'd3, 16'h0);
    check("R9", q_wf, 16'h0000);
    // R1 + R3/R4/R5: write then read back
    cyc(1, 1, 0, 4'd5, 16'hBEEF);
    cyc(1, 1, 0, 4'd5, 16'hCAFE);
    cyc(1, 0, 0, 4'd5, 16'h0);
    check("R1", q_rf, 16'hCAFE);
    // R8: write and clear together; write still lands
    cyc(1, 1, 1, 4'd6, 16'h7777);
    cyc(1, 0, 0, 4'd6, 16'h0);
    check("R8", q_nc, 16'h7777);
    // R7: clear alone keeps memory
    cyc(1, 0, 1, 4'd6, 16'h0);
    cyc(1, 0, 0, 4'd6, 16'h0);
    check("R7", q_wf, 16'h7777);
    // R5: long run of writes in no-change mode
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, AW'(k), DW'(16'h1000 + k));
    // constrained random mix, small address space for collisions
    for (int n = 0; n < 4000; n++) begin
      logic e, w, c;
      e = ($urandom_range(0, 9) < 8);
      w = ($urandom_range(0, 9) < 4);
      c = ($urandom_range(0, 9) < 1);
      cyc(e, w, c, AW'($urandom_range(0, DP - 1)), DW'($urandom));
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule